// File: doc/BRIEF.md
# Segment Register Load Checker

This block decides whether a request to load one of the six segment registers may complete. The requester supplies the target register, a 16-bit selector, the descriptor attributes it has already fetched (present bit, code/data bit, 4-bit type, descriptor privilege), the descriptor table limit and the current privilege level. In one cycle the block classifies the request. It then either writes the selector and a shadow copy of the descriptor attributes into its own register file, or it reports a fault class together with an error code.

Stack and data registers follow separate rule sets. A segment that is not present is reported as a stack fault for the stack register and as a not-present fault for the data registers. After a successful stack-register load, the block raises an interrupt-inhibit flag that covers exactly the next instruction. A second stack load inside that window does not extend it. The register file has a combinational read port, so the committed state can be observed.

Top module: `seg_load_checker`

## Requirements
- R1: A request whose target code is 1 (code register), 6 or 7 produces fault type 1 (invalid opcode) with code 0, and no register changes. Target codes are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5.
- R2: A selector whose bits 15:2 are zero is NULL. Loading a NULL selector into ES, DS, FS or GS always commits. The selector is stored and the shadow attribute byte is cleared to 0.
- R3: Loading SS with a NULL selector produces fault type 2 (general protection) with code 0.
- R4: For a non-NULL selector, the limit check fails when (selector[15:3]*8+7) is greater than the table limit. A failure produces fault type 2 with code {selector[15:2],2'b00}, for SS and for data registers alike.
- R5: For SS, fault type 2 with the selector code is produced when RPL (selector[1:0]) differs from CPL, when DPL differs from CPL, or when the segment is not a writable data segment. Writable data means code/data bit 1, type[3]=0 and type[1]=1.
- R6: For SS, when all earlier checks pass and the present bit is 0, the block produces fault type 3 (stack fault) with the selector code.
- R7: For ES, DS, FS or GS, fault type 2 with the selector code is produced when the code/data bit is 0, or when the segment is code (type[3]=1) that is not readable (type[1]=0).
- R8: For ES, DS, FS or GS, fault type 2 with the selector code is produced when the segment is data, or code that is not conforming (type[2]=0), and both RPL and CPL are numerically greater than DPL.
- R9: For ES, DS, FS or GS, when all earlier checks pass and the present bit is 0, the block produces fault type 4 (not present) with the selector code.
- R10: Checks apply in the order limit, then type and privilege, then present. Only the first failure is reported.
- R11: The cycle after a request, commit_o pulses on success and fault_type_o is nonzero on failure, never both. A commit stores the selector and the attribute byte {present, code/data, type[3:0], dpl[1:0]} in the register file. A fault leaves every register unchanged.
- R12: irq_inhibit_o rises the cycle after a committed SS load when it was clear. Any request, or an instr_done_i pulse, clears it. An SS commit while it is set does not re-arm it.
- R13: After reset all outputs are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Load request this cycle |
| target_i | input | 3 | Target register code |
| selector_i | input | 16 | Selector to load |
| desc_present_i | input | 1 | Descriptor present bit |
| desc_s_i | input | 1 | Descriptor code/data (1) or system (0) |
| desc_type_i | input | 4 | Descriptor type field |
| desc_dpl_i | input | 2 | Descriptor privilege level |
| table_limit_i | input | 16 | Descriptor table limit in bytes |
| cpl_i | input | 2 | Current privilege level |
| instr_done_i | input | 1 | Another instruction retired |
| rd_seg_i | input | 3 | Register file read index |
| commit_o | output | 1 | Load committed |
| fault_type_o | output | 3 | 0 none, 1 invalid opcode, 2 protection, 3 stack, 4 not present |
| fault_code_o | output | 16 | Error code |
| irq_inhibit_o | output | 1 | Interrupts held off for one instruction |
| rd_sel_o | output | 16 | Selector at rd_seg_i |
| rd_attr_o | output | 8 | Shadow attribute byte at rd_seg_i |

## Verification
The bench runs every target code against NULL selectors with both zero and nonzero RPL, and against selectors at the last index inside the table limit and the first index past it. Each of these is combined with all type values, both code/data settings, every DPL and CPL and both present values. The edge indices separate a correct limit compare from an off-by-one one. The privilege grid separates the stack rule, which needs exact equality, from the data rule, which needs both RPL and CPL to exceed DPL. The present sweep separates stack faults from not-present faults and shows that present is checked last. Requests run back to back, so successive SS loads test that the inhibit window does not chain. Directed steps test clearing by instr_done_i and holding while idle.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;
  typedef enum logic [2:0] {
    SEG_ES = 3'd0, SEG_CS = 3'd1, SEG_SS = 3'd2,
    SEG_DS = 3'd3, SEG_FS = 3'd4, SEG_GS = 3'd5
  } seg_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0, FLT_UD = 3'd1, FLT_GP = 3'd2,
    FLT_STACK = 3'd3, FLT_NP = 3'd4
  } fault_e;

  typedef struct packed {
    logic       present;
    logic       s;
    logic [3:0] typ;
    logic [1:0] dpl;
  } attr_t;
endpackage

// File: rtl/seg_load_rules.sv
module seg_load_rules
  import seg_load_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int LIM_W = 16
) (
  input  logic [2:0]       target_i,
  input  logic [SEL_W-1:0] sel_i,
  input  attr_t            attr_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic [1:0]       cpl_i,
  output logic             ok_o,
  output fault_e           fault_o,
  output logic [SEL_W-1:0] code_o,
  output attr_t            wattr_o
);
  localparam int CMP_W = (SEL_W > LIM_W) ? SEL_W : LIM_W;

  logic             is_stack, is_data, is_null, lim_fail;
  logic             ss_bad, data_type_bad, data_priv_bad;
  logic [1:0]       rpl;
  logic [CMP_W-1:0] last_byte, lim_ext;
  logic [SEL_W-1:0] sel_code;

  assign rpl      = sel_i[1:0];
  assign is_stack = (target_i == SEG_SS);
  assign is_data  = (target_i == SEG_ES) || (target_i == SEG_DS) ||
                    (target_i == SEG_FS) || (target_i == SEG_GS);
  assign is_null  = (sel_i[SEL_W-1:2] == '0);
  assign sel_code = {sel_i[SEL_W-1:2], 2'b00};

  assign last_byte = CMP_W'({sel_i[SEL_W-1:3], 3'b111});
  assign lim_ext   = CMP_W'(limit_i);
  assign lim_fail  = last_byte > lim_ext;

  // stack: exact privilege match, writable data only
  assign ss_bad = (rpl != cpl_i) || (attr_i.dpl != cpl_i) ||
                  !(attr_i.s && !attr_i.typ[3] && attr_i.typ[1]);
  assign data_type_bad = !attr_i.s || (attr_i.typ[3] && !attr_i.typ[1]);
  assign data_priv_bad = (!attr_i.typ[3] || !attr_i.typ[2]) &&
                         (rpl > attr_i.dpl) && (cpl_i > attr_i.dpl);

  always_comb begin
    ok_o    = 1'b0;
    fault_o = FLT_NONE;
    code_o  = '0;
    wattr_o = attr_i;
    if (!(is_stack || is_data)) begin
      fault_o = FLT_UD;
    end else if (is_null) begin
      if (is_stack) begin
        fault_o = FLT_GP;
      end else begin
        ok_o    = 1'b1;
        wattr_o = '0;
      end
    end else if (lim_fail) begin
      fault_o = FLT_GP;
      code_o  = sel_code;
    end else if (is_stack) begin
      if (ss_bad) begin
        fault_o = FLT_GP;
        code_o  = sel_code;
      end else if (!attr_i.present) begin
        fault_o = FLT_STACK;
        code_o  = sel_code;
      end else begin
        ok_o = 1'b1;
      end
    end else begin
      if (data_type_bad || data_priv_bad) begin
        fault_o = FLT_GP;
        code_o  = sel_code;
      end else if (!attr_i.present) begin
        fault_o = FLT_NP;
        code_o  = sel_code;
      end else begin
        ok_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/seg_shadow_file.sv
module seg_shadow_file
  import seg_load_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 16,
  parameter int SEG_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEG_W-1:0] wr_idx_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  attr_t            wr_attr_i,
  input  logic [SEG_W-1:0] rd_idx_i,
  output logic [SEL_W-1:0] rd_sel_o,
  output attr_t            rd_attr_o
);
  localparam int DEPTH = 1 << SEG_W;

  logic [DEPTH-1:0]            wen;
  logic [DEPTH-1:0][SEL_W-1:0] sel_q;
  attr_t [DEPTH-1:0]           attr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_wen
    if (g < NUM_SEG) begin : g_live
      assign wen[g] = we_i && (wr_idx_i == SEG_W'(g));
    end else begin : g_pad
      assign wen[g] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      attr_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wen[i]) begin
          sel_q[i]  <= wr_sel_i;
          attr_q[i] <= wr_attr_i;
        end
      end
    end
  end

  assign rd_sel_o  = sel_q[rd_idx_i];
  assign rd_attr_o = attr_q[rd_idx_i];

  // R11: state moves only on a write strobe
  p_hold_without_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(sel_q) && $stable(attr_q)));
endmodule

// File: rtl/seg_irq_shadow.sv
module seg_irq_shadow (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ss_commit_i,
  input  logic instr_done_i,
  output logic inhibit_o
);
  logic inh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          inh_q <= 1'b0;
    else if (inh_q)       inh_q <= !(req_i || instr_done_i);
    else if (ss_commit_i) inh_q <= 1'b1;
  end

  assign inhibit_o = inh_q;

  p_no_chain_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_o && (req_i || instr_done_i)) |=> !inhibit_o);
  p_arm_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inhibit_o && ss_commit_i) |=> inhibit_o);
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
  import seg_load_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 16,
  parameter int LIM_W   = 16,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [SEG_W-1:0] target_i,
  input  logic [SEL_W-1:0] selector_i,
  input  logic             desc_present_i,
  input  logic             desc_s_i,
  input  logic [3:0]       desc_type_i,
  input  logic [1:0]       desc_dpl_i,
  input  logic [LIM_W-1:0] table_limit_i,
  input  logic [1:0]       cpl_i,
  input  logic             instr_done_i,
  input  logic [SEG_W-1:0] rd_seg_i,
  output logic             commit_o,
  output logic [2:0]       fault_type_o,
  output logic [SEL_W-1:0] fault_code_o,
  output logic             irq_inhibit_o,
  output logic [SEL_W-1:0] rd_sel_o,
  output logic [7:0]       rd_attr_o
);
  attr_t            in_attr, w_attr, rd_attr;
  fault_e           rule_fault;
  logic             rule_ok, do_write;
  logic [SEL_W-1:0] rule_code;
  logic [2:0]       tgt3;
  logic             commit_q;
  fault_e           fault_q;
  logic [SEL_W-1:0] code_q;

  assign in_attr = '{present: desc_present_i, s: desc_s_i,
                     typ: desc_type_i, dpl: desc_dpl_i};
  assign tgt3    = 3'(target_i);

  seg_load_rules #(.SEL_W(SEL_W), .LIM_W(LIM_W)) i_rules (
    .target_i (tgt3),
    .sel_i    (selector_i),
    .attr_i   (in_attr),
    .limit_i  (table_limit_i),
    .cpl_i    (cpl_i),
    .ok_o     (rule_ok),
    .fault_o  (rule_fault),
    .code_o   (rule_code),
    .wattr_o  (w_attr)
  );

  assign do_write = req_valid_i && rule_ok;

  seg_shadow_file #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W), .SEG_W(SEG_W)) i_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (do_write),
    .wr_idx_i  (target_i),
    .wr_sel_i  (selector_i),
    .wr_attr_i (w_attr),
    .rd_idx_i  (rd_seg_i),
    .rd_sel_o  (rd_sel_o),
    .rd_attr_o (rd_attr)
  );

  seg_irq_shadow i_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_valid_i),
    .ss_commit_i  (do_write && (tgt3 == SEG_SS)),
    .instr_done_i (instr_done_i),
    .inhibit_o    (irq_inhibit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q <= 1'b0;
      fault_q  <= FLT_NONE;
      code_q   <= '0;
    end else begin
      commit_q <= do_write;
      fault_q  <= req_valid_i ? rule_fault : FLT_NONE;
      code_q   <= req_valid_i ? rule_code : '0;
    end
  end

  assign commit_o     = commit_q;
  assign fault_type_o = fault_q;
  assign fault_code_o = code_q;
  assign rd_attr_o    = rd_attr;

  p_code_reg_ud_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && tgt3 == SEG_CS) |=> (fault_type_o == 3'(FLT_UD) && !commit_o));
  p_null_stack_gp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && tgt3 == SEG_SS && selector_i[SEL_W-1:2] == '0)
      |=> (fault_type_o == 3'(FLT_GP) && fault_code_o == '0));
  p_commit_xor_fault_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (fault_type_o == 3'(FLT_NONE)));
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!commit_o && fault_type_o == 3'(FLT_NONE)));
endmodule

// File: tb/test_seg_load_checker.sv
module test_seg_load_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  tgt = '0;
  logic [15:0] sel = '0;
  logic        pres = 1'b0, s_bit = 1'b0;
  logic [3:0]  typ = '0;
  logic [1:0]  dpl = '0, cpl = '0;
  logic [15:0] lim = 16'h002F;
  logic        done = 1'b0;
  logic [2:0]  rd_seg = '0;
  logic        commit, inhibit;
  logic [2:0]  ftype;
  logic [15:0] fcode, rd_sel;
  logic [7:0]  rd_attr;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  logic [15:0] m_sel  [8];
  logic [7:0]  m_attr [8];
  bit          m_inh;

  always #10 clk = ~clk;

  seg_load_checker i_seg_load_checker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .target_i(tgt),
    .selector_i(sel), .desc_present_i(pres), .desc_s_i(s_bit),
    .desc_type_i(typ), .desc_dpl_i(dpl), .table_limit_i(lim), .cpl_i(cpl),
    .instr_done_i(done), .rd_seg_i(rd_seg), .commit_o(commit),
    .fault_type_o(ftype), .fault_code_o(fcode), .irq_inhibit_o(inhibit),
    .rd_sel_o(rd_sel), .rd_attr_o(rd_attr)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      if (n_fail < 20) $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // expected outcome from the requirements; ft: 0 none 1 UD 2 GP 3 stack 4 NP
  task automatic expect_of(output int ft, output int code, output bit ok);
    bit nul, lf, stack, data;
    int rpl, idx;
    rpl   = sel[1:0];
    idx   = sel[15:3];
    nul   = (sel[15:2] == 0);
    lf    = (idx * 8 + 7) > lim;
    stack = (tgt == 2);
    data  = (tgt == 0) || (tgt == 3) || (tgt == 4) || (tgt == 5);
    ft = 0; code = 0; ok = 0;
    if (!stack && !data) ft = 1;                           // R1
    else if (nul && stack) ft = 2;                          // R3
    else if (nul) ok = 1;                                   // R2
    else begin
      code = {sel[15:2], 2'b00};
      if (lf) ft = 2;                                       // R4
      else if (stack) begin
        if (rpl != cpl || dpl != cpl || !(s_bit && typ[3] == 0 && typ[1] == 1)) ft = 2; // R5
        else if (!pres) ft = 3;                             // R6
        else ok = 1;
      end else begin
        if (!s_bit || (typ[3] && !typ[1])) ft = 2;          // R7
        else if ((!typ[3] || !typ[2]) && rpl > dpl && cpl > dpl) ft = 2; // R8
        else if (!pres) ft = 4;                             // R9
        else ok = 1;
      end
      if (ft == 0 && !ok) ok = 1;
    end
    if (ok) code = 0;
  endtask

  // called at a negedge; drives one request, checks at the next negedge
  task automatic apply(input int t, input int sl, input int ty, input bit sb,
                       input int dp, input int cp, input bit pr);
    int ft, code; bit ok;
    req = 1'b1; tgt = 3'(t); sel = 16'(sl); typ = 4'(ty); s_bit = sb;
    dpl = 2'(dp); cpl = 2'(cp); pres = pr; rd_seg = 3'(t);
    expect_of(ft, code, ok);
    if (ok) begin
      m_sel[t]  = sel;
      m_attr[t] = (sel[15:2] == 0) ? 8'h00 : {pr, sb, typ, dpl};
    end
    m_inh = m_inh ? 1'b0 : (ok && t == 2);
    @(negedge clk);
    chk(ftype == 3'(ft), (ft == 1) ? "R1 fault type" : (ft == 3) ? "R6 fault type" :
        (ft == 4) ? "R9 fault type" : "R10 fault type", ftype, ft);
    chk(fcode == 16'(code), "R4 fault code", fcode, code);
    chk(commit == ok, "R11 commit", commit, ok);
    chk(rd_sel == m_sel[t] && rd_attr == m_attr[t], "R11 register file",
        {rd_sel, rd_attr}, {m_sel[t], m_attr[t]});
    chk(inhibit == m_inh, "R12 inhibit", inhibit, m_inh);
  endtask

  initial begin
    int sels[10] = '{16'h0000, 16'h0003, 16'h0028, 16'h0029, 16'h002A, 16'h002B,
                     16'h0030, 16'h0031, 16'h0032, 16'h0033};
    for (int i = 0; i < 8; i++) begin m_sel[i] = 0; m_attr[i] = 0; end
    m_inh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!commit && ftype == 0 && fcode == 0 && !inhibit, "R13 reset outputs",
        {commit, ftype, inhibit}, 0);
    for (int i = 0; i < 8; i++) begin
      rd_seg = 3'(i); #1;
      chk(rd_sel == 0 && rd_attr == 0, "R13 reset registers", rd_sel, 0);
    end
    @(negedge clk);

    // sweep
    for (int t = 0; t < 8; t++)
      for (int si = 0; si < 10; si++)
        for (int ty = 0; ty < 16; ty++)
          for (int sb = 0; sb < 2; sb++)
            for (int dp = 0; dp < 4; dp++)
              for (int cp = 0; cp < 4; cp++)
                for (int pr = 0; pr < 2; pr++) begin
                  if (t >= 6 && (si > 2 || ty > 0 || dp > 0 || cp > 0)) continue;
                  apply(t, sels[si], ty, bit'(sb), dp, cp, bit'(pr));
                end

    // R12 directed: inhibit held while idle, cleared by instr_done_i
    req = 1'b0; @(negedge clk);
    m_inh = 0;
    chk(inhibit == 0, "R12 idle after request", inhibit, 0);
    apply(2, 16'h0028, 4'h2, 1'b1, 0, 0, 1'b1);
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk(inhibit == 1, "R12 held while idle", inhibit, 1);
    done = 1'b1; @(negedge clk); done = 1'b0;
    chk(inhibit == 0, "R12 cleared by instr_done", inhibit, 0);
    @(negedge clk);
    chk(commit == 0 && ftype == 0, "R11 idle quiet", commit, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL R11 watchdog expired act=0 exp=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule